// File: doc/BRIEF.md
# Instruction-Cache Victim Way Selector

This block decides which way of a four-way instruction cache receives the next line on a miss. For each of the cache's sets it holds a complete recency ordering of the four ways. The caller presents a set index with that set's four valid bits. In the same cycle the block returns the way to replace, and a flag that is high when that way was chosen because it holds no valid line.

Empty ways always win, and the lowest-numbered empty way is taken first. When every way in the set is valid, the least recently used way is chosen. Every hit strobe with its way, and every fill strobe, updates the recency ordering of the indexed set on the next clock edge. A fill always lands in the way the block is showing as its victim at that moment. The block leaves out the tag compare, the data arrays and the sequencing of the line-fill beats.

Top module: `icache_victim_sel`

## Requirements
- R1: After reset, every set orders its ways from way0 as oldest to way3 as newest. With all ways valid, the first victim of any set is way 0, and four fills in a row then pick ways 0, 1, 2, 3.
- R2: If any bit of `way_valid` is 0 (bit i belongs to way i), `victim_way` is the lowest index whose bit is 0, and `victim_invalid` is 1. This holds whatever the recency state is.
- R3: If all four valid bits are 1, `victim_way` is the least recently used way of the indexed set, and `victim_invalid` is 0.
- R4: A cycle with `hit_vld`=1 and `fill_vld`=0 makes `hit_way` the most recently used way of the indexed set. The other ways keep their relative order.
- R5: A cycle with `fill_vld`=1 makes the way shown on `victim_way` in that cycle the most recently used way of the indexed set. The other ways keep their relative order.
- R6: When `hit_vld` and `fill_vld` are both 1 in the same cycle, only the fill's update takes place, and `hit_way` has no effect.
- R7: An update changes the ordering of the indexed set only. All other sets keep their state.
- R8: With both strobes low, no set's ordering changes, whatever value `hit_way` carries.
- R9: `victim_way` and `victim_invalid` follow `set_idx` and `way_valid` in the same cycle, with no clock edge in between. The ordering they use is the one the last clock edge wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | SET_W (5) | Set being looked up or updated |
| way_valid | input | NUM_WAYS (4) | Valid bit of each way in the indexed set, bit i for way i |
| hit_vld | input | 1 | A hit happened in the indexed set |
| hit_way | input | WAY_W (2) | Way that hit |
| fill_vld | input | 1 | A line is being written into the current victim way |
| victim_way | output | WAY_W (2) | Way chosen for replacement |
| victim_invalid | output | 1 | The victim was chosen because it is empty |

## Verification
The bench builds the block with its default parameters: 32 sets and 4 ways. At this size both edge sets, 0 and 31, can be driven, and every one of the 24 orderings of a set can be reached in a short run of hits and fills. The bench keeps its own model of each set as a list of ways from most to least recently used. It predicts each victim from that list, not from age counters. This lets it detect a wrong ageing rule, a lost update, an update that lands in the wrong set, and the wrong strobe winning a collision.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

  // Which event updates the recency state in a cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HIT  = 2'd1,
    SRC_FILL = 2'd2
  } upd_src_e;

endpackage

// File: rtl/vsel_age_store.sv
module vsel_age_store #(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SET_W-1:0]                set_idx,
  input  logic                            wr_en,
  input  logic [WAY_W-1:0]                wr_way,
  output logic [NUM_WAYS-1:0][AGE_W-1:0]  cur_ages
);

  typedef logic [NUM_WAYS-1:0][AGE_W-1:0] age_vec_t;

  // Way i starts with age NUM_WAYS-1-i: way0 oldest
  function automatic age_vec_t reset_ages();
    age_vec_t v;
    for (int i = 0; i < NUM_WAYS; i++) v[i] = AGE_W'(NUM_WAYS - 1 - i);
    return v;
  endfunction

  // Accessed way drops to age 0; ways younger than it grow one step older
  function automatic age_vec_t touch(input age_vec_t v, input logic [WAY_W-1:0] w);
    age_vec_t r;
    logic [AGE_W-1:0] pivot;
    pivot = v[w];
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (WAY_W'(i) == w)     r[i] = '0;
      else if (v[i] < pivot)  r[i] = v[i] + AGE_W'(1);
      else                    r[i] = v[i];
    end
    return r;
  endfunction

  age_vec_t ages_flat [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    age_vec_t ages_q;
    logic     sel;
    assign sel = wr_en && (set_idx == SET_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ages_q <= reset_ages();
      else if (sel) ages_q <= touch(ages_q, wr_way);
    end
    assign ages_flat[s] = ages_q;
  end

  assign cur_ages = ages_flat[set_idx];

endmodule

// File: rtl/vsel_update_ctrl.sv
module vsel_update_ctrl #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             hit_vld,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_vld,
  input  logic [WAY_W-1:0] victim_way,
  output logic             upd_en,
  output logic [WAY_W-1:0] upd_way
);
  import vsel_pkg::*;

  upd_src_e src;

  // A fill beats a hit in the same cycle
  always_comb begin
    if (fill_vld)     src = SRC_FILL;
    else if (hit_vld) src = SRC_HIT;
    else              src = SRC_NONE;
  end

  always_comb begin
    case (src)
      SRC_FILL: upd_way = victim_way;
      SRC_HIT:  upd_way = hit_way;
      default:  upd_way = '0;
    endcase
  end

  assign upd_en = (src != SRC_NONE);

endmodule

// File: rtl/vsel_victim_pick.sv
module vsel_victim_pick #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic [NUM_WAYS-1:0][AGE_W-1:0] cur_ages,
  input  logic [NUM_WAYS-1:0]            way_valid,
  output logic [WAY_W-1:0]               victim_way,
  output logic                           victim_invalid
);

  // Lowest-numbered empty way: scan downward so the lowest match wins
  function automatic logic [WAY_W-1:0] first_empty(input logic [NUM_WAYS-1:0] vld);
    logic [WAY_W-1:0] w;
    w = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) if (!vld[i]) w = WAY_W'(i);
    return w;
  endfunction

  // Way holding the top age value
  function automatic logic [WAY_W-1:0] oldest(input logic [NUM_WAYS-1:0][AGE_W-1:0] a);
    logic [WAY_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_WAYS; i++) if (a[i] == AGE_W'(NUM_WAYS - 1)) w = WAY_W'(i);
    return w;
  endfunction

  logic             any_empty;
  logic [WAY_W-1:0] empty_way;
  logic [WAY_W-1:0] lru_way;

  assign any_empty      = ~&way_valid;
  assign empty_way      = first_empty(way_valid);
  assign lru_way        = oldest(cur_ages);
  assign victim_way     = any_empty ? empty_way : lru_way;
  assign victim_invalid = any_empty;

endmodule

// File: rtl/icache_victim_sel.sv
module icache_victim_sel #(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_W-1:0]    set_idx,
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic                hit_vld,
  input  logic [WAY_W-1:0]    hit_way,
  input  logic                fill_vld,
  output logic [WAY_W-1:0]    victim_way,
  output logic                victim_invalid
);

  // Internal events, named for the checker
  logic [NUM_WAYS-1:0][AGE_W-1:0] cur_ages;
  logic                           upd_en;
  logic [WAY_W-1:0]               upd_way;

  vsel_age_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_idx  (set_idx),
    .wr_en    (upd_en),
    .wr_way   (upd_way),
    .cur_ages (cur_ages)
  );

  vsel_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .cur_ages       (cur_ages),
    .way_valid      (way_valid),
    .victim_way     (victim_way),
    .victim_invalid (victim_invalid)
  );

  vsel_update_ctrl #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .hit_vld    (hit_vld),
    .hit_way    (hit_way),
    .fill_vld   (fill_vld),
    .victim_way (victim_way),
    .upd_en     (upd_en),
    .upd_way    (upd_way)
  );

endmodule

// File: rtl/icache_victim_sel_chk.sv
module icache_victim_sel_chk #(
  parameter int NUM_WAYS = 4,
  parameter int SET_W = 5,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int AGE_W = WAY_W
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [SET_W-1:0]               set_idx,
  input logic [NUM_WAYS-1:0]            way_valid,
  input logic                           hit_vld,
  input logic [WAY_W-1:0]               hit_way,
  input logic                           fill_vld,
  input logic [WAY_W-1:0]               victim_way,
  input logic                           victim_invalid,
  input logic [NUM_WAYS-1:0][AGE_W-1:0] cur_ages,
  input logic                           upd_en,
  input logic [WAY_W-1:0]               upd_way
);

  // Which age values are present in the indexed set
  logic [NUM_WAYS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < NUM_WAYS; i++)
      for (int k = 0; k < NUM_WAYS; k++)
        if (cur_ages[i] == AGE_W'(k)) age_seen[k] = 1'b1;
  end

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (~&way_valid) |-> (victim_invalid && !way_valid[victim_way])); // R2

  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (&way_valid) |-> !victim_invalid); // R3

  AST_FULL_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (&way_valid) |-> (cur_ages[victim_way] == AGE_W'(NUM_WAYS - 1))); // R3

  AST_AGES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    &age_seen); // R4

  AST_HIT_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld && !fill_vld) |=> ((set_idx != $past(set_idx)) || (cur_ages[$past(hit_way)] == '0))); // R4

  AST_FILL_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld |=> ((set_idx != $past(set_idx)) || (cur_ages[$past(victim_way)] == '0))); // R5

  AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld && fill_vld) |-> (upd_en && upd_way == victim_way)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_vld && !fill_vld) |=> ((set_idx != $past(set_idx)) || $stable(cur_ages))); // R8

endmodule

bind icache_victim_sel icache_victim_sel_chk #(.NUM_WAYS(NUM_WAYS), .SET_W(SET_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .set_idx        (set_idx),
  .way_valid      (way_valid),
  .hit_vld        (hit_vld),
  .hit_way        (hit_way),
  .fill_vld       (fill_vld),
  .victim_way     (victim_way),
  .victim_invalid (victim_invalid),
  .cur_ages       (cur_ages),
  .upd_en         (upd_en),
  .upd_way        (upd_way)
);

// File: tb/icache_victim_sel_tb.sv
`timescale 1ns/1ps
module icache_victim_sel_tb;

  localparam int SETS = 32;
  localparam int WAYS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] set_idx = '0;
  logic [3:0] way_valid = '0;
  logic       hit_vld = 1'b0;
  logic [1:0] hit_way = '0;
  logic       fill_vld = 1'b0;
  logic [1:0] victim_way;
  logic       victim_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model: per set, ways listed from most to least recently used
  int order [SETS][WAYS];

  always #2.5 clk = ~clk;

  icache_victim_sel u_dut (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .way_valid(way_valid),
    .hit_vld(hit_vld), .hit_way(hit_way), .fill_vld(fill_vld),
    .victim_way(victim_way), .victim_invalid(victim_invalid)
  );

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int p = 0; p < WAYS; p++) order[s][p] = WAYS - 1 - p;
  endtask

  task automatic model_touch(input int s, input int w);
    int pos = 0;
    for (int p = 0; p < WAYS; p++) if (order[s][p] == w) pos = p;
    for (int p = pos; p > 0; p--) order[s][p] = order[s][p-1];
    order[s][0] = w;
  endtask

  function automatic int exp_victim(input int s, input logic [3:0] vld);
    for (int i = 0; i < WAYS; i++) if (!vld[i]) return i;
    return order[s][WAYS-1];
  endfunction

  // One cycle: drive at the falling edge, check the outputs 1 ns later, update the model at the rising edge
  task automatic step(input string req, input int s, input logic [3:0] vld,
                      input bit hv, input int hw, input bit fv);
    int ev;
    int ei;
    @(negedge clk);
    set_idx = 5'(s); way_valid = vld; hit_vld = hv; hit_way = 2'(hw); fill_vld = fv;
    #1;
    ev = exp_victim(s, vld);
    ei = (vld != 4'hF) ? 1 : 0;
    checks++;
    if (int'(victim_way) != ev || int'(victim_invalid) != ei) begin
      errors++;
      $display("FAIL %s set=%0d valid=%b: victim=%0d inv=%0d expected victim=%0d inv=%0d",
               req, s, vld, victim_way, victim_invalid, ev, ei);
    end
    if (fv) model_touch(s, ev);
    else if (hv) model_touch(s, hw);
  endtask

  task automatic t_reset();
    step("R1", 0, 4'hF, 0, 0, 0);
    step("R1", 31, 4'hF, 0, 0, 0);
    for (int k = 0; k < 5; k++) step("R1", 20, 4'hF, 0, 0, 1);
  endtask

  task automatic t_empty();
    step("R2", 2, 4'h0, 0, 0, 0);
    step("R2", 2, 4'h1, 0, 0, 0);
    step("R2", 2, 4'hB, 0, 0, 0);
    step("R2", 2, 4'h7, 0, 0, 0);
    step("R2", 2, 4'hA, 1, 0, 0);
    step("R2", 2, 4'hD, 1, 3, 0);
    step("R3", 2, 4'hF, 0, 0, 0);
  endtask

  task automatic t_hits();
    step("R4", 5, 4'hF, 1, 0, 0);
    step("R4", 5, 4'hF, 1, 2, 0);
    step("R4", 5, 4'hF, 1, 1, 0);
    step("R4", 5, 4'hF, 1, 2, 0);
    step("R4", 5, 4'hF, 1, 3, 0);
    step("R4", 5, 4'hF, 0, 0, 0);
  endtask

  task automatic t_fills();
    step("R5", 7, 4'hF, 1, 2, 0);
    step("R5", 7, 4'hF, 0, 0, 1);
    step("R5", 7, 4'h5, 0, 0, 1);
    step("R5", 7, 4'hF, 0, 0, 1);
    step("R5", 7, 4'hF, 0, 0, 0);
  endtask

  task automatic t_collide();
    step("R6", 9, 4'hF, 1, 1, 1);
    step("R6", 9, 4'hF, 0, 0, 0);
    step("R6", 9, 4'hF, 1, 2, 1);
    step("R6", 9, 4'hF, 0, 0, 0);
  endtask

  task automatic t_isolate();
    step("R7", 10, 4'hF, 1, 0, 0);
    step("R7", 10, 4'hF, 0, 0, 1);
    step("R7", 11, 4'hF, 0, 0, 0);
    step("R7", 9, 4'hF, 0, 0, 0);
    step("R7", 10, 4'hF, 0, 0, 0);
  endtask

  task automatic t_idle();
    for (int k = 0; k < WAYS; k++) step("R8", 12, 4'hF, 0, k, 0);
    step("R8", 12, 4'hF, 0, 0, 0);
  endtask

  task automatic t_mixed();
    logic [15:0] lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int s;
      logic [3:0] vld;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      s = int'(lf[4:0]);
      vld = lf[15] ? lf[9:6] : 4'hF;
      step("R9", s, vld, lf[5], int'(lf[11:10]), lf[12] & lf[14]);
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty();
    t_hits();
    t_fills();
    t_collide();
    t_isolate();
    t_idle();
    t_mixed();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule